// File: doc/BRIEF.md
# DMA Descriptor Fetch and Decode Unit

This block serves one DMA channel. A channel pointer register holds the byte address of the current descriptor. While the channel is enabled, the block reads that descriptor word by word over a request/grant memory port. It learns the descriptor's kind from the first word. It then reads only the words that this kind defines, and it presents the decoded fields to a transfer engine over a valid/ready output. Fields that the kind does not define read as zero on the output.

After the engine has accepted a descriptor, the block waits for a one-cycle completion pulse from the engine. If the descriptor's link word is non-zero, the block loads the link into the channel pointer and fetches the next descriptor. A zero link ends the chain. An unknown kind code stops the fetch after the first word and raises a sticky error flag.

Back-pressure on the output works as follows. Once `dscr_valid` rises, it stays high and every field stays unchanged until a cycle in which `dscr_ready` is high. Only that cycle transfers the descriptor. The memory side applies back-pressure through `mem_gnt`. The request and its address are held until a grant arrives, and read data is taken in the granted cycle.

Top module: `dscr_fetch_unit`

## Requirements
- R1: After reset `mem_req`, `dscr_valid`, `busy`, `chain_done` and `dscr_err` are low and `cur_ptr` is zero.
- R2: A `ch_ptr_wr` with non-zero data while the block is not busy loads `cur_ptr` and sets `busy`. A zero value, or any write while busy, is ignored. No read is requested while `ch_enable` is low before a fetch starts, and `mem_req` is only ever high while `busy` is high.
- R3: The kind code is word 0 bits [2:0]: 0 single, 1 scatter, 2 memory copy, 3 one-dimensional, 4 two-dimensional. A descriptor of these kinds takes exactly 4, 4, 5, 6 and 8 reads respectively. The reads go to `cur_ptr`, `cur_ptr+4`, `cur_ptr+8` and so on, in that order.
- R4: While `mem_req` is high without `mem_gnt`, the request and `mem_addr` are held in the next cycle (unless `ch_clear` intervenes).
- R5: Field placement by word index: source is word 1 for all kinds. Destination is word 2 for every kind except scatter. X count is word 2 for scatter and word 3 for memory copy, 1D and 2D. X increments are word 4 (1D, 2D). Y count is word 5 and Y increments are word 6 (2D only). The link word is word 3 for single and scatter, word 4 for memory copy, word 5 for 1D and word 7 for 2D. Fields a kind lacks are output as zero, and `dscr_ctl` is word 0.
- R6: `dscr_xcnt` and `dscr_ycnt` are 17-bit element counts: the low 16 bits of the stored word plus one. A stored 0xFFFF gives 65536 and a stored 0 gives 1, and the upper 16 bits of the word are ignored.
- R7: While `dscr_valid` is high and `dscr_ready` low, `dscr_valid` and all fields stay unchanged next cycle, and no memory read is requested.
- R8: After the accepted descriptor's `eng_done` pulse, a non-zero link is loaded into `cur_ptr` and the next descriptor is fetched, so a whole chain is delivered in link order.
- R9: A zero link at `eng_done` clears `busy` and gives a `chain_done` pulse of exactly one cycle, during which `busy` is low.
- R10: An unknown kind code (5 to 7) stops after the single read of word 0. No descriptor is presented, `busy` clears, and `dscr_err` is set and stays set until `ch_clear`.
- R11: `ch_clear` returns the block from any state to idle in the next cycle. `cur_ptr` becomes zero, and `busy`, `dscr_err`, `mem_req` and `dscr_valid` go low.
- R12: `dscr_prio` carries the `ch_prio` value sampled when word 0 of that descriptor was granted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| ch_enable | input | 1 | Channel enable; gates the start of each fetch |
| ch_prio | input | PRIO_W | Channel priority |
| ch_ptr_wr | input | 1 | Write strobe for the channel pointer |
| ch_ptr_wdata | input | ADDR_W | Descriptor start address to load |
| ch_clear | input | 1 | Channel de-initialise: clears pointer, busy and error |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Byte address of the requested word |
| mem_gnt | input | 1 | Grant; read data valid in the same cycle |
| mem_rdata | input | DATA_W | Read data |
| dscr_valid | output | 1 | Decoded descriptor available |
| dscr_ready | input | 1 | Engine accepts the descriptor |
| dscr_ctl | output | DATA_W | Control word (word 0) |
| dscr_src | output | DATA_W | Source address |
| dscr_dst | output | DATA_W | Destination address, zero if absent |
| dscr_xcnt | output | CNT_W+1 | X element count, zero if absent |
| dscr_xinc | output | DATA_W | X increments word, zero if absent |
| dscr_ycnt | output | CNT_W+1 | Y element count, zero if absent |
| dscr_yinc | output | DATA_W | Y increments word, zero if absent |
| dscr_next | output | DATA_W | Link to the next descriptor |
| dscr_prio | output | PRIO_W | Priority captured for this descriptor |
| eng_done | input | 1 | Engine finished the accepted descriptor |
| busy | output | 1 | A chain is in progress |
| chain_done | output | 1 | One-cycle pulse when a chain ends |
| dscr_err | output | 1 | Sticky unknown-kind error |
| cur_ptr | output | ADDR_W | Current descriptor pointer |

## Verification
The main pattern is a five-descriptor chain that holds all five kinds in memory, with grants and ready stalled at pseudo-random points. This chain shows whether each kind reads exactly its own words, at the right addresses and in link order. Because absent fields sit on top of words that other kinds use, it also shows whether a field was taken from the wrong word. A standalone two-dimensional descriptor with extreme counts separates the minus-one count encoding from a plain copy, and a different priority shows whether the priority is captured per descriptor. An unknown kind code, a clear issued during a stalled request, and pointer writes while disabled, while busy or with zero data test the abort, clear and ignore paths.

// File: rtl/dscr_pkg.sv
package dscr_pkg;

  localparam int KIND_W    = 3;
  localparam int WORDS_MAX = 8;
  localparam int IDX_W     = $clog2(WORDS_MAX);

  // fixed word positions shared by every kind that has the field
  localparam int W_CTL  = 0;
  localparam int W_SRC  = 1;
  localparam int W_DST  = 2;
  localparam int W_XINC = 4;
  localparam int W_YCNT = 5;
  localparam int W_YINC = 6;

  typedef enum logic [KIND_W-1:0] {
    K_SINGLE  = 3'd0,
    K_SCATTER = 3'd1,
    K_MEMCPY  = 3'd2,
    K_LINE    = 3'd3,
    K_PLANE   = 3'd4
  } dscr_kind_e;

  typedef struct packed {
    logic             ok;
    logic [IDX_W-1:0] last;
    logic             has_dst;
    logic             has_x;
    logic [IDX_W-1:0] x_at;
    logic             has_xinc;
    logic             has_y;
    logic [IDX_W-1:0] nxt_at;
  } layout_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_FETCH,
    S_SHOW,
    S_RUN
  } seq_st_e;

endpackage

// File: rtl/dscr_layout.sv
module dscr_layout
  import dscr_pkg::*;
(
  input  logic [KIND_W-1:0] kind,
  output layout_t           lay
);

  always_comb begin
    lay = '0;
    case (kind)
      K_SINGLE: begin
        lay.ok      = 1'b1;
        lay.last    = IDX_W'(3);
        lay.has_dst = 1'b1;
        lay.nxt_at  = IDX_W'(3);
      end
      K_SCATTER: begin
        lay.ok      = 1'b1;
        lay.last    = IDX_W'(3);
        lay.has_x   = 1'b1;
        lay.x_at    = IDX_W'(2);
        lay.nxt_at  = IDX_W'(3);
      end
      K_MEMCPY: begin
        lay.ok      = 1'b1;
        lay.last    = IDX_W'(4);
        lay.has_dst = 1'b1;
        lay.has_x   = 1'b1;
        lay.x_at    = IDX_W'(3);
        lay.nxt_at  = IDX_W'(4);
      end
      K_LINE: begin
        lay.ok       = 1'b1;
        lay.last     = IDX_W'(5);
        lay.has_dst  = 1'b1;
        lay.has_x    = 1'b1;
        lay.x_at     = IDX_W'(3);
        lay.has_xinc = 1'b1;
        lay.nxt_at   = IDX_W'(5);
      end
      K_PLANE: begin
        lay.ok       = 1'b1;
        lay.last     = IDX_W'(7);
        lay.has_dst  = 1'b1;
        lay.has_x    = 1'b1;
        lay.x_at     = IDX_W'(3);
        lay.has_xinc = 1'b1;
        lay.has_y    = 1'b1;
        lay.nxt_at   = IDX_W'(7);
      end
      default: lay = '0;
    endcase
  end

endmodule

// File: rtl/dscr_word_store.sv
module dscr_word_store
  import dscr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  layout_t           lay,
  output logic [KIND_W-1:0] kind,
  output logic [DATA_W-1:0] ctl,
  output logic [DATA_W-1:0] src,
  output logic [DATA_W-1:0] dst,
  output logic [CNT_W:0]    xcnt,
  output logic [DATA_W-1:0] xinc,
  output logic [CNT_W:0]    ycnt,
  output logic [DATA_W-1:0] yinc,
  output logic [DATA_W-1:0] nxt
);

  logic [DATA_W-1:0] words [WORDS_MAX];

  for (genvar g = 0; g < WORDS_MAX; g++) begin : g_word
    logic [DATA_W-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                 q <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))      q <= wr_data;
    end
    assign words[g] = q;
  end

  logic unused_lay;
  assign unused_lay = ^lay.last;

  assign kind = words[W_CTL][KIND_W-1:0];
  assign ctl  = words[W_CTL];
  assign src  = words[W_SRC];
  assign dst  = lay.has_dst  ? words[W_DST]  : '0;
  assign xinc = lay.has_xinc ? words[W_XINC] : '0;
  assign yinc = lay.has_y    ? words[W_YINC] : '0;
  assign xcnt = lay.has_x ? ({1'b0, words[lay.x_at][CNT_W-1:0]} + (CNT_W+1)'(1)) : '0;
  assign ycnt = lay.has_y ? ({1'b0, words[W_YCNT][CNT_W-1:0]} + (CNT_W+1)'(1)) : '0;
  assign nxt  = lay.ok ? words[lay.nxt_at] : '0;

endmodule

// File: rtl/dscr_seq.sv
module dscr_seq
  import dscr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_enable,
  input  logic [PRIO_W-1:0] ch_prio,
  input  logic              ch_ptr_wr,
  input  logic [ADDR_W-1:0] ch_ptr_wdata,
  input  logic              ch_clear,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  layout_t           lay_live,
  input  logic [ADDR_W-1:0] next_ptr,
  output logic              wr_en,
  output logic [IDX_W-1:0]  widx,
  output logic              dscr_valid,
  input  logic              dscr_ready,
  input  logic              eng_done,
  output logic              busy,
  output logic              chain_done,
  output logic              dscr_err,
  output logic [ADDR_W-1:0] cur_ptr,
  output logic [PRIO_W-1:0] prio_q
);

  seq_st_e           st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] ptr_q;
  logic              busy_q, err_q, done_q;

  logic unused_lay;
  assign unused_lay = ^lay_live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      idx_q  <= '0;
      ptr_q  <= '0;
      busy_q <= 1'b0;
      err_q  <= 1'b0;
      done_q <= 1'b0;
      prio_q <= '0;
    end else begin
      done_q <= 1'b0;
      if (ch_clear) begin
        st_q   <= S_IDLE;
        idx_q  <= '0;
        ptr_q  <= '0;
        busy_q <= 1'b0;
        err_q  <= 1'b0;
      end else begin
        case (st_q)
          S_IDLE: begin
            if (!busy_q) begin
              if (ch_ptr_wr && ch_ptr_wdata != '0) begin
                ptr_q  <= ch_ptr_wdata;
                busy_q <= 1'b1;
              end
            end else if (ch_enable) begin
              st_q  <= S_FETCH;
              idx_q <= '0;
            end
          end
          S_FETCH: begin
            if (mem_gnt) begin
              if (idx_q == '0) prio_q <= ch_prio;
              if (!lay_live.ok) begin
                err_q  <= 1'b1;
                busy_q <= 1'b0;
                st_q   <= S_IDLE;
              end else if (idx_q == lay_live.last) begin
                st_q <= S_SHOW;
              end else begin
                idx_q <= idx_q + IDX_W'(1);
              end
            end
          end
          S_SHOW: if (dscr_ready) st_q <= S_RUN;
          S_RUN: begin
            if (eng_done) begin
              st_q <= S_IDLE;
              if (next_ptr != '0) begin
                ptr_q <= next_ptr;
              end else begin
                busy_q <= 1'b0;
                done_q <= 1'b1;
              end
            end
          end
          default: st_q <= S_IDLE;
        endcase
      end
    end
  end

  assign mem_req    = (st_q == S_FETCH);
  assign mem_addr   = ptr_q + ADDR_W'({idx_q, 2'b00});
  assign wr_en      = mem_req && mem_gnt;
  assign widx       = idx_q;
  assign dscr_valid = (st_q == S_SHOW);
  assign busy       = busy_q;
  assign chain_done = done_q;
  assign dscr_err   = err_q;
  assign cur_ptr    = ptr_q;

  assert_req_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> busy);

  assert_hold_req_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && !mem_gnt && !ch_clear |=> mem_req && $stable(mem_addr));

  assert_valid_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dscr_valid && !dscr_ready && !ch_clear |=> dscr_valid && !mem_req);

  assert_done_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |-> !busy);

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    chain_done |=> !chain_done);

  assert_err_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
    dscr_err && !ch_clear |=> dscr_err);

  assert_clear_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ch_clear |=> !busy && !dscr_err && !mem_req && !dscr_valid && cur_ptr == '0);

endmodule

// File: rtl/dscr_fetch_unit.sv
module dscr_fetch_unit
  import dscr_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 16,
  parameter int PRIO_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ch_enable,
  input  logic [PRIO_W-1:0] ch_prio,
  input  logic              ch_ptr_wr,
  input  logic [ADDR_W-1:0] ch_ptr_wdata,
  input  logic              ch_clear,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_gnt,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              dscr_valid,
  input  logic              dscr_ready,
  output logic [DATA_W-1:0] dscr_ctl,
  output logic [DATA_W-1:0] dscr_src,
  output logic [DATA_W-1:0] dscr_dst,
  output logic [CNT_W:0]    dscr_xcnt,
  output logic [DATA_W-1:0] dscr_xinc,
  output logic [CNT_W:0]    dscr_ycnt,
  output logic [DATA_W-1:0] dscr_yinc,
  output logic [DATA_W-1:0] dscr_next,
  output logic [PRIO_W-1:0] dscr_prio,
  input  logic              eng_done,
  output logic              busy,
  output logic              chain_done,
  output logic              dscr_err,
  output logic [ADDR_W-1:0] cur_ptr
);

  logic              wr_en;
  logic [IDX_W-1:0]  widx;
  logic [KIND_W-1:0] kind_stored, kind_live;
  layout_t           lay_live, lay_stored;

  // during word 0 the kind comes straight from the bus, afterwards from storage
  assign kind_live = (widx == '0) ? mem_rdata[KIND_W-1:0] : kind_stored;

  dscr_layout u_lay_live   (.kind(kind_live),   .lay(lay_live));
  dscr_layout u_lay_stored (.kind(kind_stored), .lay(lay_stored));

  dscr_word_store #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (widx),
    .wr_data (mem_rdata),
    .lay     (lay_stored),
    .kind    (kind_stored),
    .ctl     (dscr_ctl),
    .src     (dscr_src),
    .dst     (dscr_dst),
    .xcnt    (dscr_xcnt),
    .xinc    (dscr_xinc),
    .ycnt    (dscr_ycnt),
    .yinc    (dscr_yinc),
    .nxt     (dscr_next)
  );

  dscr_seq #(.ADDR_W(ADDR_W), .PRIO_W(PRIO_W)) u_seq (
    .clk          (clk),
    .rst_n        (rst_n),
    .ch_enable    (ch_enable),
    .ch_prio      (ch_prio),
    .ch_ptr_wr    (ch_ptr_wr),
    .ch_ptr_wdata (ch_ptr_wdata),
    .ch_clear     (ch_clear),
    .mem_req      (mem_req),
    .mem_addr     (mem_addr),
    .mem_gnt      (mem_gnt),
    .lay_live     (lay_live),
    .next_ptr     (ADDR_W'(dscr_next)),
    .wr_en        (wr_en),
    .widx         (widx),
    .dscr_valid   (dscr_valid),
    .dscr_ready   (dscr_ready),
    .eng_done     (eng_done),
    .busy         (busy),
    .chain_done   (chain_done),
    .dscr_err     (dscr_err),
    .cur_ptr      (cur_ptr),
    .prio_q       (dscr_prio)
  );

  assert_fields_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
    dscr_valid && !dscr_ready && !ch_clear |=>
      $stable(dscr_next) && $stable(dscr_src) && $stable(dscr_xcnt) && $stable(dscr_prio));

endmodule

// File: tb/dscr_fetch_unit_tb_top.sv
`timescale 1ns/1ps
module dscr_fetch_unit_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ch_enable = 1'b0;
  logic [1:0]  ch_prio = 2'd0;
  logic        ch_ptr_wr = 1'b0;
  logic [31:0] ch_ptr_wdata = '0;
  logic        ch_clear = 1'b0;
  logic        mem_req, mem_gnt;
  logic [31:0] mem_addr, mem_rdata;
  logic        dscr_valid;
  logic        dscr_ready = 1'b0;
  logic [31:0] dscr_ctl, dscr_src, dscr_dst, dscr_xinc, dscr_yinc, dscr_next;
  logic [16:0] dscr_xcnt, dscr_ycnt;
  logic [1:0]  dscr_prio;
  logic        eng_done = 1'b0;
  logic        busy, chain_done, dscr_err;
  logic [31:0] cur_ptr;

  always #2 clk = ~clk;

  dscr_fetch_unit dut_i (
    .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_prio(ch_prio),
    .ch_ptr_wr(ch_ptr_wr), .ch_ptr_wdata(ch_ptr_wdata), .ch_clear(ch_clear),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_gnt(mem_gnt), .mem_rdata(mem_rdata),
    .dscr_valid(dscr_valid), .dscr_ready(dscr_ready), .dscr_ctl(dscr_ctl),
    .dscr_src(dscr_src), .dscr_dst(dscr_dst), .dscr_xcnt(dscr_xcnt),
    .dscr_xinc(dscr_xinc), .dscr_ycnt(dscr_ycnt), .dscr_yinc(dscr_yinc),
    .dscr_next(dscr_next), .dscr_prio(dscr_prio), .eng_done(eng_done),
    .busy(busy), .chain_done(chain_done), .dscr_err(dscr_err), .cur_ptr(cur_ptr)
  );

  // memory model
  logic [31:0] mem [0:255];
  logic        gnt_en = 1'b0;
  logic        stall_all = 1'b0;
  logic [7:0]  lfsr = 8'hA5;
  assign mem_gnt   = mem_req && gnt_en;
  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk) begin
    lfsr       <= {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
    gnt_en     <= !stall_all && (lfsr[0] || lfsr[3]);
    dscr_ready <= lfsr[5] || lfsr[6];
  end

  int n_chk = 0;
  int n_err = 0;
  int chain_cnt = 0;
  int done_wait = 0;
  int cyc = 0;

  task automatic chk(input bit ok, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", what, act, exp);
    end
  endtask

  typedef struct {
    logic [31:0] ctl, src, dst, xinc, yinc, nxt;
    logic [16:0] xcnt, ycnt;
    logic [1:0]  prio;
  } exp_t;

  exp_t        exp_q[$];
  logic [31:0] addr_q[$];

  // driver: lays a descriptor into memory and queues what must come out
  task automatic put_dscr(input logic [31:0] base, input logic [2:0] kind,
                          input logic [31:0] src, input logic [31:0] dst,
                          input logic [31:0] xw, input logic [31:0] xinc,
                          input logic [31:0] yw, input logic [31:0] yinc,
                          input logic [31:0] nxt, input logic [1:0] prio);
    exp_t e;
    int n;
    logic [31:0] w [8];
    for (int i = 0; i < 8; i++) w[i] = 32'hDEAD_0000 | i;
    e.ctl = 32'h5A00_0000 | {29'd0, kind};
    e.src = src; e.dst = '0; e.xinc = '0; e.yinc = '0; e.nxt = nxt;
    e.xcnt = '0; e.ycnt = '0; e.prio = prio;
    w[0] = e.ctl; w[1] = src;
    case (kind)
      3'd0: begin n = 4; w[2] = dst; w[3] = nxt; e.dst = dst; end
      3'd1: begin n = 4; w[2] = xw; w[3] = nxt; e.xcnt = {1'b0, xw[15:0]} + 17'd1; end
      3'd2: begin n = 5; w[2] = dst; w[3] = xw; w[4] = nxt; e.dst = dst;
                  e.xcnt = {1'b0, xw[15:0]} + 17'd1; end
      3'd3: begin n = 6; w[2] = dst; w[3] = xw; w[4] = xinc; w[5] = nxt; e.dst = dst;
                  e.xcnt = {1'b0, xw[15:0]} + 17'd1; e.xinc = xinc; end
      3'd4: begin n = 8; w[2] = dst; w[3] = xw; w[4] = xinc; w[5] = yw; w[6] = yinc; w[7] = nxt;
                  e.dst = dst; e.xcnt = {1'b0, xw[15:0]} + 17'd1; e.xinc = xinc;
                  e.ycnt = {1'b0, yw[15:0]} + 17'd1; e.yinc = yinc; end
      default: n = 1;
    endcase
    for (int i = 0; i < 8; i++) mem[(base >> 2) + i] = w[i];
    for (int i = 0; i < n; i++) addr_q.push_back(base + 32'(4 * i));
    if (kind <= 3'd4) exp_q.push_back(e);
  endtask

  task automatic wr_ptr(input logic [31:0] v);
    @(negedge clk);
    ch_ptr_wr = 1'b1; ch_ptr_wdata = v;
    @(negedge clk);
    ch_ptr_wr = 1'b0;
  endtask

  // monitor / scoreboard
  logic        p_req = 0, p_gnt = 0, p_val = 0, p_rdy = 0, p_clr = 0, p_cd = 0;
  logic [31:0] p_addr = '0, p_nxt = '0;

  always @(negedge clk) begin : mon
    exp_t e;
    logic [31:0] a;
    if (rst_n) begin
      eng_done = 1'b0;
      if (done_wait > 0) begin
        done_wait--;
        if (done_wait == 0) eng_done = 1'b1;
      end
      if (mem_req && mem_gnt) begin
        if (addr_q.size() == 0) chk(1'b0, "R3 read beyond descriptor", mem_addr, 0);
        else begin
          a = addr_q.pop_front();
          chk(mem_addr == a, "R3 read address", mem_addr, a);
        end
      end
      if (p_req && !p_gnt && !p_clr)
        chk(mem_req && mem_addr == p_addr, "R4 request held", {mem_req, mem_addr}, {1'b1, p_addr});
      if (p_val && !p_rdy && !p_clr)
        chk(dscr_valid && !mem_req && dscr_next == p_nxt, "R7 valid and fields held",
            {dscr_valid, mem_req, dscr_next}, {2'b10, p_nxt});
      if (dscr_valid && dscr_ready) begin
        if (exp_q.size() == 0) chk(1'b0, "R8 unexpected descriptor", dscr_ctl, 0);
        else begin
          e = exp_q.pop_front();
          chk(dscr_ctl  == e.ctl,  "R5 ctl",        dscr_ctl,  e.ctl);
          chk(dscr_src  == e.src,  "R5 src",        dscr_src,  e.src);
          chk(dscr_dst  == e.dst,  "R5 dst",        dscr_dst,  e.dst);
          chk(dscr_xinc == e.xinc, "R5 xinc",       dscr_xinc, e.xinc);
          chk(dscr_yinc == e.yinc, "R5 yinc",       dscr_yinc, e.yinc);
          chk(dscr_next == e.nxt,  "R5 next",       dscr_next, e.nxt);
          chk(dscr_xcnt == e.xcnt, "R6 xcount",     dscr_xcnt, e.xcnt);
          chk(dscr_ycnt == e.ycnt, "R6 ycount",     dscr_ycnt, e.ycnt);
          chk(dscr_prio == e.prio, "R12 priority",  dscr_prio, e.prio);
        end
        done_wait = 3;
      end
      if (chain_done) begin
        chain_cnt++;
        chk(!busy, "R9 busy low with chain_done", busy, 0);
      end
      if (p_cd) chk(!chain_done, "R9 single-cycle pulse", chain_done, 0);
      p_req = mem_req; p_gnt = mem_gnt; p_addr = mem_addr;
      p_val = dscr_valid; p_rdy = dscr_ready; p_nxt = dscr_next;
      p_clr = ch_clear; p_cd = chain_done;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 20000) begin
      n_chk++; n_err++;
      $display("FAIL watchdog R8 act=hung exp=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = '0;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(!mem_req && !dscr_valid && !busy && !chain_done && !dscr_err, "R1 outputs in reset",
        {mem_req, dscr_valid, busy, chain_done, dscr_err}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cur_ptr == 0 && !busy, "R1 pointer after reset", cur_ptr, 0);

    // chain of all five kinds: 2D -> single -> scatter -> memcpy -> 1D
    ch_prio = 2'd1;
    put_dscr(32'h040, 3'd4, 32'h1000, 32'h2000, 32'hABCD_0003, 32'h0004_0002, 32'h0000_0001, 32'h0010_0020, 32'h080, 2'd1);
    put_dscr(32'h080, 3'd0, 32'h1100, 32'h2100, 0, 0, 0, 0, 32'h0C0, 2'd1);
    put_dscr(32'h0C0, 3'd1, 32'h1200, 0, 32'h0000_0000, 0, 0, 0, 32'h100, 2'd1);
    put_dscr(32'h100, 3'd2, 32'h1300, 32'h2300, 32'h0000_FFFF, 0, 0, 0, 32'h140, 2'd1);
    put_dscr(32'h140, 3'd3, 32'h1400, 32'h2400, 32'h0000_0007, 32'h0001_0001, 0, 0, 32'h0, 2'd1);

    wr_ptr(32'h0);
    chk(!busy, "R2 zero pointer ignored", busy, 0);
    wr_ptr(32'h040);
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (mem_req) chk(1'b0, "R2 no read while disabled", mem_req, 0);
    end
    chk(busy && cur_ptr == 32'h040, "R2 pointer loaded", {busy, cur_ptr}, {1'b1, 32'h040});
    ch_enable = 1'b1;
    @(negedge clk);
    wr_ptr(32'h3C0);
    chk(cur_ptr == 32'h040, "R2 write while busy ignored", cur_ptr, 32'h040);
    while (chain_cnt < 1) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R8 whole chain delivered",
        {exp_q.size(), addr_q.size()}, 0);
    chk(cur_ptr == 32'h140 && !busy, "R8 pointer on last descriptor", cur_ptr, 32'h140);

    // standalone 2D with extreme counts and another priority
    ch_prio = 2'd2;
    put_dscr(32'h240, 3'd4, 32'h5000, 32'h6000, 32'h0000_0000, 32'h0008_0008, 32'h7777_FFFF, 32'h0100_0100, 32'h0, 2'd2);
    wr_ptr(32'h240);
    while (chain_cnt < 2) @(negedge clk);
    @(negedge clk);
    chk(exp_q.size() == 0 && addr_q.size() == 0, "R6 2D descriptor delivered",
        {exp_q.size(), addr_q.size()}, 0);

    // unknown kind code
    put_dscr(32'h2C0, 3'd6, 32'h9, 32'h9, 32'h9, 32'h9, 32'h9, 32'h9, 32'h300, 2'd2);
    wr_ptr(32'h2C0);
    for (int i = 0; i < 40 && !dscr_err; i++) @(negedge clk);
    @(negedge clk);
    chk(dscr_err && !busy && !dscr_valid, "R10 error raised, fetch stopped",
        {dscr_err, busy, dscr_valid}, 3'b100);
    chk(addr_q.size() == 0, "R10 only word 0 read", addr_q.size(), 0);
    repeat (5) @(negedge clk);
    chk(dscr_err && !mem_req, "R10 error sticky", dscr_err, 1);
    ch_clear = 1'b1;
    @(negedge clk);
    ch_clear = 1'b0;
    chk(!dscr_err && !busy && cur_ptr == 0, "R11 clear from error", {dscr_err, busy, cur_ptr}, 0);

    // clear during a stalled request
    stall_all = 1'b1;
    repeat (2) @(negedge clk);
    wr_ptr(32'h380);
    repeat (4) @(negedge clk);
    chk(mem_req && mem_addr == 32'h380, "R3 first read at pointer", mem_addr, 32'h380);
    ch_clear = 1'b1;
    @(negedge clk);
    ch_clear = 1'b0;
    chk(!mem_req && !busy && !dscr_valid && cur_ptr == 0, "R11 clear mid-fetch",
        {mem_req, busy, dscr_valid, cur_ptr}, 0);
    stall_all = 1'b0;
    repeat (3) @(negedge clk);

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule